// File: doc/BRIEF.md
# Receive Statistics Counter Bank

This block keeps five receive statistics counters for a network interface. Once per finished frame, the receive path raises a one-cycle completion strobe. With the strobe comes a status word made of an OK bit, a 2-bit destination class, a frame byte count and two error flags. One error flag marks wire errors. The other marks frames that were dropped because the receive FIFO overran.

From each status word the bank counts the following:

- the octets received in good frames;
- the number of good frames;
- good broadcast frames;
- good multicast frames;
- errored frames.

Every counter saturates at all ones and never wraps.

Software reads one counter at a time through a small synchronous read port. A read can also clear the counter it returns. A separate clear-all input zeroes the whole bank.

Top module: `rxstat_bank`

## Requirements
- R1: When `stat_valid` is high and `stat_ok` is 1, the octets counter (read address 0) adds `stat_bytes`, which is the full frame length including the address, type, data and FCS fields.
- R2: When `stat_valid` is high and `stat_ok` is 1, the good-frames counter (address 1) adds one, for every destination class.
- R3: The broadcast counter (address 2) adds one only when `stat_valid` is high, `stat_ok` is 1 and `stat_dest` is 2'b11.
- R4: The multicast counter (address 3) adds one only when `stat_valid` is high, `stat_ok` is 1 and `stat_dest` is 2'b10. Classes 2'b00 and 2'b01 affect only the octets and good-frames counters.
- R5: The errored counter (address 4) adds one for each strobe that has `stat_wire_err` or `stat_ovf_drop` set, whatever the value of `stat_ok`. A frame with both flags set counts once.
- R6: Every counter stops at 2^CNT_W-1 and never wraps.
- R7: A read with `rd_en` high at an edge places the addressed counter's value on `rd_data` from the next cycle on. That value is the one held before any update in the same cycle. Addresses 5 to 7 return 0. `rd_data` holds its value while `rd_en` is low.
- R8: A read with `rd_cor` high clears the addressed counter. A strobe that lands in the same cycle becomes the counter's new value. A read with `rd_cor` low leaves the counter unchanged.
- R9: `clear_all` zeroes every counter in the next cycle and discards any strobe in the same cycle. Reset zeroes every counter and `rd_data`.
- R10: While `stat_valid` is low, the status fields have no effect on any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_valid | input | 1 | One-cycle frame completion strobe |
| stat_ok | input | 1 | Frame received without error |
| stat_dest | input | 2 | Destination class: 11 broadcast, 10 multicast, others unicast |
| stat_bytes | input | BYTE_W | Frame length in bytes |
| stat_wire_err | input | 1 | Frame rejected for a wire error |
| stat_ovf_drop | input | 1 | Frame dropped for FIFO overrun |
| clear_all | input | 1 | Zero every counter |
| rd_en | input | 1 | Read request |
| rd_cor | input | 1 | Clear the addressed counter on this read |
| rd_addr | input | 3 | Counter select, 0 to 4 |
| rd_data | output | CNT_W | Registered read value |

## Verification
The bench sweeps all 32 combinations of OK, destination class and the two error flags. Each combination gets a distinct byte count. This separates the broadcast and multicast selection from the unicast classes, and it shows that the error flags count independently of OK. Strobes with the valid bit low but every field set show that R10 holds. Clear-on-read is tried both with an idle strobe and with a strobe in the same cycle, which tells a discarded update apart from a kept one. Long runs of maximum-size frames and of good frames drive the octets and frame counters into saturation.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

    localparam int NUM_CNT = 5;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        CNT_OCTETS = 3'd0,
        CNT_GOOD   = 3'd1,
        CNT_BCAST  = 3'd2,
        CNT_MCAST  = 3'd3,
        CNT_ERRED  = 3'd4
    } cnt_sel_e;

    localparam logic [1:0] DEST_BCAST = 2'b11;
    localparam logic [1:0] DEST_MCAST = 2'b10;

    // Per-frame classification handed from decoder to the counter cells
    typedef struct packed {
        logic good;
        logic bcast;
        logic mcast;
        logic erred;
    } frame_class_t;

    function automatic frame_class_t classify(input logic vld, input logic ok,
                                              input logic [1:0] dest,
                                              input logic werr, input logic ovf);
        frame_class_t c;
        c.good  = vld & ok;
        c.bcast = vld & ok & (dest == DEST_BCAST);
        c.mcast = vld & ok & (dest == DEST_MCAST);
        c.erred = vld & (werr | ovf);
        return c;
    endfunction

endpackage

// File: rtl/rxstat_decode.sv
module rxstat_decode
    import rxstat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BYTE_W = 16
) (
    input  logic                             stat_valid,
    input  logic                             stat_ok,
    input  logic [1:0]                       stat_dest,
    input  logic [BYTE_W-1:0]                stat_bytes,
    input  logic                             stat_wire_err,
    input  logic                             stat_ovf_drop,
    output logic [NUM_CNT-1:0][CNT_W-1:0]    inc
);
    frame_class_t cls;

    always_comb begin
        cls = classify(stat_valid, stat_ok, stat_dest, stat_wire_err, stat_ovf_drop);
        inc = '0;
        inc[CNT_OCTETS] = cls.good  ? CNT_W'(stat_bytes) : '0;
        inc[CNT_GOOD]   = CNT_W'(cls.good);
        inc[CNT_BCAST]  = CNT_W'(cls.bcast);
        inc[CNT_MCAST]  = CNT_W'(cls.mcast);
        inc[CNT_ERRED]  = CNT_W'(cls.erred);
    end

    // R2: every broadcast or multicast frame is also a good frame
    always_comb begin
        a_r2_good_covers: assert ((inc[CNT_BCAST] == '0 && inc[CNT_MCAST] == '0) || inc[CNT_GOOD] == CNT_W'(1));
        // R10: an idle strobe produces no increment anywhere
        a_r10_idle_quiet: assert (stat_valid || inc == '0);
    end

endmodule

// File: rtl/rxstat_cell.sv
module rxstat_cell #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             rd_clr,
    input  logic [CNT_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        base = rd_clr ? '0 : cnt;
        sum  = {1'b0, base} + {1'b0, inc};
        nxt  = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= nxt;
    end

    // R6: a saturated counter stays saturated until cleared
    a_r6_hold_max: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !clr && !rd_clr) |=> cnt == CNT_MAX);
    // R6: without a clear the counter never moves backward (no wrap)
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!clr && !rd_clr) |=> cnt >= $past(cnt));
    // R9: clear-all empties the counter
    a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);
    // R8: the update landing in a clear-on-read cycle becomes the value
    a_r8_keep_update: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !clr) |=> cnt == $past(inc));

endmodule

// File: rtl/rxstat_bank.sv
module rxstat_bank
    import rxstat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BYTE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stat_valid,
    input  logic               stat_ok,
    input  logic [1:0]         stat_dest,
    input  logic [BYTE_W-1:0]  stat_bytes,
    input  logic               stat_wire_err,
    input  logic               stat_ovf_drop,
    input  logic               clear_all,
    input  logic               rd_en,
    input  logic               rd_cor,
    input  logic [2:0]         rd_addr,
    output logic [CNT_W-1:0]   rd_data
);
    logic [NUM_CNT-1:0][CNT_W-1:0] inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    logic [CNT_W-1:0]              sel_val;

    rxstat_decode #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_dec (
        .stat_valid    (stat_valid),
        .stat_ok       (stat_ok),
        .stat_dest     (stat_dest),
        .stat_bytes    (stat_bytes),
        .stat_wire_err (stat_wire_err),
        .stat_ovf_drop (stat_ovf_drop),
        .inc           (inc)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cell
        logic rd_clr_i;
        assign rd_clr_i = rd_en && rd_cor && (rd_addr == ADDR_W'(i));
        rxstat_cell #(.CNT_W(CNT_W)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .clr    (clear_all),
            .rd_clr (rd_clr_i),
            .inc    (inc[i]),
            .cnt    (cnt[i])
        );
    end

    always_comb begin
        sel_val = '0;
        for (int k = 0; k < NUM_CNT; k++)
            if (rd_addr == ADDR_W'(k)) sel_val = cnt[k];
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= sel_val;
    end

    // R7: read data holds while no read is issued
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
    // R7: unmapped addresses read as zero
    a_r7_unmapped: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr >= ADDR_W'(NUM_CNT)) |=> rd_data == '0);
    // R3/R4: a frame is never both broadcast and multicast
    a_r3_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(inc[CNT_BCAST] != '0 && inc[CNT_MCAST] != '0));
    // R5: errored counter moves by at most one per cycle
    a_r5_one_step: assert property (@(posedge clk) disable iff (rst)
        (!clear_all && !(rd_en && rd_cor)) |=> cnt[CNT_ERRED] - $past(cnt[CNT_ERRED]) <= CNT_W'(1));

endmodule

// File: tb/rxstat_bank_test.sv
module rxstat_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int BW = 8;
    localparam int MAXV = (1 << CW) - 1;

    logic clk = 0;
    logic rst;
    logic stat_valid, stat_ok, stat_wire_err, stat_ovf_drop;
    logic [1:0] stat_dest;
    logic [BW-1:0] stat_bytes;
    logic clear_all, rd_en, rd_cor;
    logic [2:0] rd_addr;
    logic [CW-1:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int m [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxstat_bank #(.CNT_W(CW), .BYTE_W(BW)) uut (
        .clk(clk), .rst(rst), .stat_valid(stat_valid), .stat_ok(stat_ok),
        .stat_dest(stat_dest), .stat_bytes(stat_bytes), .stat_wire_err(stat_wire_err),
        .stat_ovf_drop(stat_ovf_drop), .clear_all(clear_all), .rd_en(rd_en),
        .rd_cor(rd_cor), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        stat_valid = 0; stat_ok = 0; stat_dest = 0; stat_bytes = 0;
        stat_wire_err = 0; stat_ovf_drop = 0; clear_all = 0;
        rd_en = 0; rd_cor = 0; rd_addr = 0;
    endtask

    // One cycle: optional strobe, optional read, optional clear. Returns the
    // expected read value (pre-update) for a read issued this cycle.
    task automatic cyc(input bit v, input bit ok, input logic [1:0] d, input int b,
                       input bit we, input bit od, input bit re, input bit cor,
                       input int a, input bit clr, output int exp_rd);
        stat_valid = v; stat_ok = ok; stat_dest = d; stat_bytes = BW'(b);
        stat_wire_err = we; stat_ovf_drop = od; clear_all = clr;
        rd_en = re; rd_cor = cor; rd_addr = 3'(a);
        exp_rd = (a < 5) ? m[a] : 0;
        if (clr) begin
            for (int k = 0; k < 5; k++) m[k] = 0;
        end else begin
            if (re && cor && a < 5) m[a] = 0;
            if (v && ok) begin
                m[0] = sat(m[0] + b);
                m[1] = sat(m[1] + 1);
                if (d == 2'b11) m[2] = sat(m[2] + 1);
                if (d == 2'b10) m[3] = sat(m[3] + 1);
            end
            if (v && (we || od)) m[4] = sat(m[4] + 1);
        end
        @(posedge clk); #1;
        idle();
    endtask

    task automatic pkt(input bit ok, input logic [1:0] d, input int b, input bit we, input bit od);
        int x;
        cyc(1, ok, d, b, we, od, 0, 0, 0, 0, x);
    endtask

    task automatic rd_chk(input int a, input bit cor, input string req);
        int e;
        cyc(0, 0, 0, 0, 0, 0, 1, cor, a, 0, e);
        chk(req, int'(rd_data), e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int e;
        idle();
        for (int k = 0; k < 5; k++) m[k] = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset rd_data", int'(rd_data), 0);
        rst = 0;
        for (int a = 0; a < 5; a++) rd_chk(a, 0, "R9 reset counter");

        // R10: fields set but strobe low
        for (int i = 0; i < 4; i++) cyc(0, 1, 2'(i), 200, 1, 1, 0, 0, 0, 0, e);
        for (int a = 0; a < 5; a++) rd_chk(a, 0, "R10 idle strobe ignored");

        // Full sweep of ok x dest x wire_err x ovf_drop
        for (int i = 0; i < 32; i++)
            pkt(i[4], 2'(i[3:2]), 10 + 7 * i, i[1], i[0]);
        rd_chk(0, 0, "R1 octets sweep");
        rd_chk(1, 0, "R2 good sweep");
        rd_chk(2, 0, "R3 bcast sweep");
        rd_chk(3, 0, "R4 mcast sweep");
        rd_chk(4, 0, "R5 errored sweep");
        rd_chk(0, 0, "R8 read without cor keeps value");
        for (int a = 5; a < 8; a++) rd_chk(a, 0, "R7 unmapped address");

        // R7: rd_data holds when rd_en low
        rd_chk(1, 0, "R7 read good");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, e);
        chk("R7 hold while idle", int'(rd_data), m[1]);

        // R7/R8: read returns pre-update value; cor keeps same-cycle update
        cyc(1, 1, 2'b11, 50, 0, 0, 1, 1, 0, 0, e);
        chk("R7 read old value with update", int'(rd_data), e);
        rd_chk(0, 0, "R8 cor keeps same-cycle update");
        rd_chk(2, 1, "R8 cor read bcast");
        rd_chk(2, 0, "R8 cor cleared bcast");
        rd_chk(4, 1, "R8 cor read errored");
        rd_chk(4, 0, "R8 cor cleared errored");

        // R9: clear_all discards same-cycle strobe
        cyc(1, 1, 2'b10, 99, 1, 0, 0, 0, 0, 1, e);
        for (int a = 0; a < 5; a++) rd_chk(a, 0, "R9 clear_all");

        // R6: octet saturation with max-size frames
        for (int i = 0; i < 300; i++) pkt(1, 2'b10, 255, 0, 1);
        rd_chk(0, 0, "R6 octets saturate");
        rd_chk(3, 0, "R4 mcast run");
        rd_chk(4, 0, "R5 overrun-only errors");

        // R6: frame counter saturation
        for (int i = 0; i < MAXV + 10; i++) pkt(1, 2'b11, 1, 1, 0);
        rd_chk(1, 0, "R6 good saturate");
        rd_chk(2, 0, "R6 bcast saturate");
        rd_chk(4, 0, "R6 errored saturate");
        chk("R6 model at max", m[1], MAXV);
        rd_chk(1, 1, "R6 cor of saturated");
        rd_chk(1, 0, "R8 zero after cor");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule